// File: doc/BRIEF.md
# Two-Wire Bus Byte Status and Event Controller

This block is the byte-level status and event logic of a two-wire serial bus controller that can run as master or as slave. A bit-level front end, which is not part of this block, reports bus conditions to it as single-cycle strobes. These are start and stop detection, one strobe per sampled data bit, the ninth-clock acknowledge value, and address-match indications. The block keeps an 8-bit shift register that moves data most significant bit first. It also keeps a set of event flags that the host clears by writing ones.

The host reaches the block through a small register port. Select 0 is the data shift register and select 1 is the status byte. The block asks the front end to hold the serial clock low while data is pending or while a stall after the address phase is in effect. It raises an interrupt for the stall flag and for the new-match flag when their enables are set. A start-control input keeps a host read of received data from releasing the data-ready flag. This lets a repeated start be prepared while receiving as master.

Top module: `twi_event_ctrl`

## Requirements
- R1: Each `bitStrobe` shifts the data register left by one place and loads `sdaIn` into bit 0. `sdaOut` is always bit 7. A host write to select 0 loads the whole byte, and select 0 reads back the current byte.
- R2: The status byte at select 1 has this layout: bit 0 data-ready, bit 1 new match, bit 2 stall, bit 3 negative acknowledge, bit 4 bus error, bit 5 slave stop, and bits 7:6 always 0. A host write to select 1 clears every flag in bits 5:1 whose write bit is 1. Flags whose write bit is 0 are left unchanged.
- R3: The status byte is 00h after reset. While `enable` is low it reads 00h one cycle later, and bus events are ignored.
- R4: Bus error is set when `startSeen` or `stopSeen` arrives while `inByte` is high, or when `arbLost` is high.
- R5: An `ackStrobe` with `ackVal` = 1 sets negative acknowledge and leaves data-ready clear.
- R6: An `ackStrobe` with `ackVal` = 0 sets data-ready. A host read of select 0 with `isTransmit` low clears it. A host write of select 0 with `isTransmit` high clears it.
- R7: While `startCtl` is high, a host read of select 0 does not clear data-ready.
- R8: In master mode with `stallEn` high, a successful address acknowledge with no bus error in the same cycle sets the stall flag. In slave mode it never does. `holdScl` is high while the block is enabled and either the stall flag or data-ready is set.
- R9: `irq` is the OR of (stall AND `irqEn`) and (new match AND `matchIrqEn`). It falls in the same cycle that the host write clears the last such flag.
- R10: In slave mode, an address acknowledge with `addrMatch` or `gcMatch` high sets new match. A later `stopSeen` then sets slave stop once.
- R11: When a hardware set and a host clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable |
| isMaster | input | 1 | 1 = master mode, 0 = slave mode |
| isTransmit | input | 1 | 1 = this side transmits the current byte |
| stallEn | input | 1 | Enable stall after address phase |
| startCtl | input | 1 | Start-control bit; keeps data-ready on host reads |
| irqEn | input | 1 | Interrupt enable for the stall flag |
| matchIrqEn | input | 1 | Interrupt enable for the new-match flag |
| startSeen | input | 1 | Start or repeated start detected (strobe) |
| stopSeen | input | 1 | Stop detected (strobe) |
| inByte | input | 1 | High during data bits and acknowledge cycle of a byte |
| bitStrobe | input | 1 | One data bit sampled (strobe) |
| sdaIn | input | 1 | Sampled data bit |
| ackStrobe | input | 1 | Ninth clock completed (strobe) |
| ackVal | input | 1 | Acknowledge level on ninth clock, 1 = not acknowledged |
| addrPhase | input | 1 | Current byte is the address byte |
| addrMatch | input | 1 | Address matched own address |
| gcMatch | input | 1 | Address is a general call |
| arbLost | input | 1 | Arbitration problem detected |
| hostSel | input | 1 | Register select: 0 data, 1 status |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data for the selected register |
| sdaOut | output | 1 | Data bit to transmit (register bit 7) |
| holdScl | output | 1 | Request to hold the serial clock low |
| irq | output | 1 | Interrupt request |

## Verification
A wrong flag shows at the status port, and at `irq` or `holdScl`, in the cycle right after the event strobe that set it or the host write that should have cleared it. Nothing in the flag path is delayed by more than one register. A shift register fault appears on `sdaOut` at the next bit strobe, or in the byte read back after eight bits. A fault in the data-ready clear or hold rules shows one cycle after the host access, while the clock hold request stays high when it should have dropped.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int DATA_W = 8;
  localparam int FLAG_DR = 0;
  localparam int FLAG_NM = 1;
  localparam int FLAG_ST = 2;
  localparam int FLAG_NA = 3;
  localparam int FLAG_BE = 4;
  localparam int FLAG_SS = 5;
  localparam int NUM_FLAGS = 6;

  typedef struct packed {
    logic load;
    logic shift;
  } dpStrobe_t;
endpackage

// File: rtl/twi_datapath.sv
module twi_datapath
  import twi_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpStrobe_t    strobe,
  input  logic [W-1:0] loadData,
  input  logic         sdaIn,
  output logic [W-1:0] shData,
  output logic         sdaOut
);
  localparam int MSB = W - 1;

  always_ff @(posedge clk) begin
    if (!rstN)             shData <= '0;
    else if (strobe.load)  shData <= loadData;
    else if (strobe.shift) shData <= {shData[MSB-1:0], sdaIn};
  end

  assign sdaOut = shData[MSB];

  // R1
  shift_in_lsb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shift && !strobe.load) |=> shData[0] == $past(sdaIn));

  // R1
  shift_msb_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shift && !strobe.load) |=> shData[MSB:1] == $past(shData[MSB-1:0]));
endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         isMaster,
  input  logic         isTransmit,
  input  logic         stallEn,
  input  logic         startCtl,
  input  logic         irqEn,
  input  logic         matchIrqEn,
  input  logic         startSeen,
  input  logic         stopSeen,
  input  logic         inByte,
  input  logic         bitStrobe,
  input  logic         ackStrobe,
  input  logic         ackVal,
  input  logic         addrPhase,
  input  logic         addrMatch,
  input  logic         gcMatch,
  input  logic         arbLost,
  input  logic         hostSel,
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic [W-1:0] hostWdata,
  output dpStrobe_t    strobe,
  output logic [W-1:0] statusByte,
  output logic         holdScl,
  output logic         irq
);
  logic [NUM_FLAGS-1:0] flags, flagSet, flagClr;
  logic slvActive;
  logic berSet, drClr;

  assign strobe.load  = hostWr && !hostSel;
  assign strobe.shift = bitStrobe && enable;

  always_comb begin
    berSet = ((startSeen || stopSeen) && inByte) || arbLost;
    flagSet = '0;
    flagSet[FLAG_DR] = ackStrobe && !ackVal;
    flagSet[FLAG_NA] = ackStrobe && ackVal;
    flagSet[FLAG_BE] = berSet;
    flagSet[FLAG_ST] = ackStrobe && !ackVal && addrPhase && isMaster && stallEn && !berSet;
    flagSet[FLAG_NM] = ackStrobe && addrPhase && !isMaster && (addrMatch || gcMatch);
    flagSet[FLAG_SS] = stopSeen && (slvActive || flagSet[FLAG_NM]);
  end

  assign drClr = !hostSel && ((hostRd && !isTransmit && !startCtl) || (hostWr && isTransmit));

  always_comb begin
    flagClr = '0;
    for (int i = 1; i < NUM_FLAGS; i++) flagClr[i] = hostWr && hostSel && hostWdata[i];
    flagClr[FLAG_DR] = drClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      flags     <= '0;
      slvActive <= 1'b0;
    end else begin
      flags <= (flags & ~flagClr) | flagSet;
      if (flagSet[FLAG_NM])  slvActive <= 1'b1;
      else if (stopSeen)     slvActive <= 1'b0;
    end
  end

  always_comb begin
    statusByte = '0;
    statusByte[NUM_FLAGS-1:0] = flags;
  end

  assign holdScl = enable && (flags[FLAG_ST] || flags[FLAG_DR]);
  assign irq = (irqEn && flags[FLAG_ST]) || (matchIrqEn && flags[FLAG_NM]);

  // R3
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> statusByte == '0);

  // R2
  w1c_zero_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && flags[FLAG_BE] && hostWr && hostSel && !hostWdata[FLAG_BE]) |=> flags[FLAG_BE]);

  // R5
  nack_no_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && ackStrobe && ackVal && !flags[FLAG_DR]) |=> !flags[FLAG_DR] && flags[FLAG_NA]);

  // R8
  slave_no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isMaster && !flags[FLAG_ST]) |=> !flags[FLAG_ST]);

  // R11
  match_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && ackStrobe && addrPhase && !isMaster && (addrMatch || gcMatch)) |=> flags[FLAG_NM]);

  // R7
  start_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && flags[FLAG_DR] && startCtl && !isTransmit && !hostWr) |=> flags[FLAG_DR]);
endmodule

// File: rtl/twi_event_ctrl.sv
module twi_event_ctrl
  import twi_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                isMaster,
  input  logic                isTransmit,
  input  logic                stallEn,
  input  logic                startCtl,
  input  logic                irqEn,
  input  logic                matchIrqEn,
  input  logic                startSeen,
  input  logic                stopSeen,
  input  logic                inByte,
  input  logic                bitStrobe,
  input  logic                sdaIn,
  input  logic                ackStrobe,
  input  logic                ackVal,
  input  logic                addrPhase,
  input  logic                addrMatch,
  input  logic                gcMatch,
  input  logic                arbLost,
  input  logic                hostSel,
  input  logic                hostWr,
  input  logic                hostRd,
  input  logic [DATA_W-1:0]   hostWdata,
  output logic [DATA_W-1:0]   hostRdata,
  output logic                sdaOut,
  output logic                holdScl,
  output logic                irq
);
  dpStrobe_t          strobe;
  logic [DATA_W-1:0]  shData;
  logic [DATA_W-1:0]  statusByte;

  twi_ctrl #(.W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .isMaster(isMaster),
    .isTransmit(isTransmit), .stallEn(stallEn), .startCtl(startCtl),
    .irqEn(irqEn), .matchIrqEn(matchIrqEn), .startSeen(startSeen),
    .stopSeen(stopSeen), .inByte(inByte), .bitStrobe(bitStrobe),
    .ackStrobe(ackStrobe), .ackVal(ackVal), .addrPhase(addrPhase),
    .addrMatch(addrMatch), .gcMatch(gcMatch), .arbLost(arbLost),
    .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd), .hostWdata(hostWdata),
    .strobe(strobe), .statusByte(statusByte), .holdScl(holdScl), .irq(irq)
  );

  twi_datapath #(.W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadData(hostWdata),
    .sdaIn(sdaIn), .shData(shData), .sdaOut(sdaOut)
  );

  assign hostRdata = hostSel ? statusByte : shData;

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (hostSel ? hostRdata[2:1] != 2'b00 : 1'b1));
endmodule

// File: tb/tb_twi_event_ctrl.sv
module tb_twi_event_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  // [26]master [25]transmit [24]stallEn [23]start [22]stop [21]inByte
  // [20]ack [19]ackVal [18]addrPhase [17]match [16]status-write [15:8]wdata [7:0]expected status
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0016_0003, 32'h0000_0003, 32'h0001_0003, 32'h0001_0201,
    32'h0040_0021, 32'h0001_2001, 32'h0040_0001, 32'h00A0_0011,
    32'h0001_1001, 32'h0714_0005, 32'h0715_0405, 32'h0701_0401,
    32'h071C_0009, 32'h0701_0801, 32'h0116_0003, 32'h0101_0201
  };

  logic clk = 1'b0;
  logic rstN, enable, isMaster, isTransmit, stallEn, startCtl, irqEn, matchIrqEn;
  logic startSeen, stopSeen, inByte, bitStrobe, sdaIn, ackStrobe, ackVal;
  logic addrPhase, addrMatch, gcMatch, arbLost, hostSel, hostWr, hostRd;
  logic [7:0] hostWdata, hostRdata;
  logic sdaOut, holdScl, irq;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_event_ctrl dut (
    .clk(clk), .rstN(rstN), .enable(enable), .isMaster(isMaster),
    .isTransmit(isTransmit), .stallEn(stallEn), .startCtl(startCtl),
    .irqEn(irqEn), .matchIrqEn(matchIrqEn), .startSeen(startSeen),
    .stopSeen(stopSeen), .inByte(inByte), .bitStrobe(bitStrobe), .sdaIn(sdaIn),
    .ackStrobe(ackStrobe), .ackVal(ackVal), .addrPhase(addrPhase),
    .addrMatch(addrMatch), .gcMatch(gcMatch), .arbLost(arbLost),
    .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .sdaOut(sdaOut), .holdScl(holdScl), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic clearPulses();
    startSeen = 0; stopSeen = 0; inByte = 0; bitStrobe = 0; ackStrobe = 0;
    ackVal = 0; addrPhase = 0; addrMatch = 0; gcMatch = 0; arbLost = 0;
    hostWr = 0; hostRd = 0; hostWdata = 8'h00; hostSel = 1'b1;
  endtask

  task automatic step();
    @(posedge clk); #1;
    clearPulses();
    #1;
  endtask

  task automatic statusWrite(input logic [7:0] val);
    hostSel = 1; hostWr = 1; hostWdata = val;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearPulses();
    rstN = 0; enable = 1; isMaster = 0; isTransmit = 0; stallEn = 0;
    startCtl = 0; irqEn = 1; matchIrqEn = 1; sdaIn = 0;
    repeat (3) @(posedge clk);
    #1; rstN = 1; #1;
    // R3 reset state
    check("R3 reset status", hostRdata, 8'h00);
    check("R3 reset irq/hold", {6'b0, irq, holdScl}, 8'h00);

    // table walk: R2 R4 R6 R8 R10 R11 R9
    for (int i = 0; i < NVEC; i++) begin
      isMaster = VEC[i][26]; isTransmit = VEC[i][25]; stallEn = VEC[i][24];
      startSeen = VEC[i][23]; stopSeen = VEC[i][22]; inByte = VEC[i][21];
      ackStrobe = VEC[i][20]; ackVal = VEC[i][19]; addrPhase = VEC[i][18];
      addrMatch = VEC[i][17]; hostSel = 1; hostWr = VEC[i][16];
      hostWdata = VEC[i][15:8];
      step();
      check($sformatf("R2/R4/R10/R11 vector %0d status", i), hostRdata, VEC[i][7:0]);
      check($sformatf("R9 vector %0d irq", i), {7'b0, irq}, {7'b0, VEC[i][1] | VEC[i][2]});
    end

    // R7 start-control keeps data-ready on read
    isMaster = 1; isTransmit = 0; startCtl = 1;
    hostSel = 0; hostRd = 1; step();
    check("R7 read with start control", hostRdata, 8'h01);
    startCtl = 0;
    hostSel = 0; hostRd = 1; step();
    check("R6 read clears data-ready", hostRdata, 8'h00);
    check("R8 hold released", {7'b0, holdScl}, 8'h00);

    // R5 negative acknowledge without data-ready
    isTransmit = 1;
    ackStrobe = 1; ackVal = 1; step();
    check("R5 nack only", hostRdata, 8'h08);
    statusWrite(8'h08);
    check("R2 nack cleared", hostRdata, 8'h00);

    // R1 shift MSB first out and in
    hostSel = 0; hostWr = 1; hostWdata = 8'hA5; step();
    hostSel = 0; #1;
    check("R1 load readback", hostRdata, 8'hA5);
    for (int b = 0; b < 8; b++) begin
      logic [7:0] outPat, inPat;
      outPat = 8'hA5; inPat = 8'h3C;
      check($sformatf("R1 sdaOut bit %0d", b), {7'b0, sdaOut}, {7'b0, outPat[7-b]});
      bitStrobe = 1; sdaIn = inPat[7-b];
      step();
    end
    hostSel = 0; #1;
    check("R1 shifted-in byte", hostRdata, 8'h3C);
    hostSel = 1; #1;
    check("R6 host write in transmit leaves data-ready clear", hostRdata, 8'h00);

    // R8 / R9 stall, hold and interrupt
    stallEn = 1;
    ackStrobe = 1; addrPhase = 1; step();
    check("R8 stall set", hostRdata, 8'h05);
    check("R8 hold and R9 irq", {6'b0, irq, holdScl}, 8'h03);
    irqEn = 0; #1;
    check("R9 irq masked", {7'b0, irq}, 8'h00);
    irqEn = 1; #1;
    hostSel = 0; hostWr = 1; hostWdata = 8'h11; step();
    hostSel = 1; hostWr = 1; hostWdata = 8'h04;
    @(posedge clk); #1;
    check("R9 irq falls on clear", {6'b0, irq, holdScl}, 8'h00);
    clearPulses(); #1;

    // R9 new-match enable
    isMaster = 0; matchIrqEn = 0;
    ackStrobe = 1; addrPhase = 1; gcMatch = 1; step();
    check("R10 general call match", hostRdata & 8'h02, 8'h02);
    check("R9 match irq masked", {7'b0, irq}, 8'h00);
    matchIrqEn = 1; #1;
    check("R9 match irq enabled", {7'b0, irq}, 8'h01);

    // R3 disable clears and ignores events
    enable = 0; step();
    check("R3 disabled clear", hostRdata, 8'h00);
    ackStrobe = 1; ackVal = 1; arbLost = 1; step();
    check("R3 events ignored while disabled", hostRdata, 8'h00);
    check("R3 irq low while disabled", {6'b0, irq, holdScl}, 8'h00);
    enable = 1;
    arbLost = 1; step();
    check("R4 arbitration problem", hostRdata, 8'h10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule